// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one channel that sits beside a free-running 16-bit timer and gives that timer three uses through a single 16-bit value register. As a capture unit it copies the timer into the register when an input event happens. The event is an edge on a synchronised external pin, or a strobe from a message receiver that turns each capture into a receive timestamp. As a compare unit it watches for the timer equalling the register. On a match it can toggle, set or clear the channel pin, raise the interrupt flag only, or emit a one-cycle pulse that the surrounding logic uses to restart the timer. As a PWM unit it drives the pin with a 10-bit duty cycle that changes only at period boundaries.

The timer and the PWM period generator are outside the block. They appear only as the `tmr_val` input and the `pwm_roll` strobe. Software programs the channel through a byte-wide write port with four addresses. The value register is also brought out directly as `cap_val`.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `pin_out`, `irq_flag` and `spec_evt` are 0 and `cap_val` is 0x0000.
- R2: Register writes take effect at the clock edge where `wr_en` is high. The addresses are: 0 = control (bits 3:0 mode, bits 5:4 duty low bits, bit 7 alternate-source select); 1 = value bits 7:0; 2 = value bits 15:8; 3 = flag clear, where a write with bit 0 set clears the flag.
- R3: Mode codes 0000, 0001 and 0011 disable the channel: no capture happens, `irq_flag` is held at 0, the pin is driven low and the capture prescaler restarts from zero.
- R4: Mode 0101 copies `tmr_val` into the value register on each rising edge of `pin_in`, and mode 0100 does so on each falling edge. `pin_in` passes through a two-flop synchroniser first.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The count starts fresh whenever the mode changes.
- R6: With control bit 7 set, each one-cycle `alt_evt` pulse is the capture event in place of the pin, and capture happens at the edge where the pulse is sampled.
- R7: Every capture and every compare match sets `irq_flag`. The flag stays set until cleared through address 3. An event in the same cycle as the clear wins, and the flag stays set.
- R8: Mode 0010 toggles `pin_out` once per match. A match is the first cycle in which `tmr_val` equals the value register, so a timer that holds the matching value does not toggle the pin again.
- R9: Entering mode 1000 drives the pin low and a match forces it high. Entering mode 1001 drives the pin high and a match forces it low.
- R10: Mode 1010 sets only `irq_flag` on a match and leaves `pin_out` unchanged, including the level it had when the mode was entered.
- R11: Mode 1011 produces a single-cycle `spec_evt` pulse in the cycle after a match and sets `irq_flag`.
- R12: Modes 11xx give PWM. The 10-bit duty is {value bits 7:0, control bits 5:4} and is latched at `pwm_roll`. The pin goes high at the roll and stays high for exactly duty clock cycles. A duty written during a period applies from the next roll onward.
- R13: A latched PWM duty of zero keeps `pin_out` low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External capture pin level (asynchronous) |
| alt_evt | input | 1 | One-cycle message-received strobe, alternate capture source |
| tmr_val | input | 16 | Current value of the external timer |
| pwm_roll | input | 1 | One-cycle PWM period rollover strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| pin_out | output | 1 | Channel pin drive |
| irq_flag | output | 1 | Sticky interrupt flag |
| spec_evt | output | 1 | One-cycle timer-reset pulse |
| cap_val | output | 16 | Contents of the value register |

## Verification
The hardest situation to reach is a prescaler that has counted part of the way and is then thrown back to zero by a mode change. The bench gives two rising edges in mode 0110, passes through mode 0000, returns to 0110, and then shows that three more edges do not capture and the fourth does. The flag collision needs an `alt_evt` pulse and a flag-clear write in the same cycle, and the bench drives both from one task. For PWM, the bench counts high cycles on a running counter, so a duty written in the middle of a period can be shown to take effect only after the next roll.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF,
    ROLE_CAP,
    ROLE_CMP,
    ROLE_PWM
  } role_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_VLO  = 2'd1;
  localparam logic [1:0] ADR_VHI  = 2'd2;
  localparam logic [1:0] ADR_FCLR = 2'd3;

  localparam logic [3:0] M_TOGGLE  = 4'b0010;
  localparam logic [3:0] M_FALL    = 4'b0100;
  localparam logic [3:0] M_RISE    = 4'b0101;
  localparam logic [3:0] M_PRE_A   = 4'b0110;
  localparam logic [3:0] M_PRE_B   = 4'b0111;
  localparam logic [3:0] M_SET_HI  = 4'b1000;
  localparam logic [3:0] M_SET_LO  = 4'b1001;
  localparam logic [3:0] M_IRQ     = 4'b1010;
  localparam logic [3:0] M_SPECIAL = 4'b1011;

  function automatic role_e role_of(input logic [3:0] m);
    role_e r;
    if (m[3:2] == 2'b11)      r = ROLE_PWM;
    else if (m[3])            r = ROLE_CMP;
    else if (m[2])            r = ROLE_CAP;
    else if (m == M_TOGGLE)   r = ROLE_CMP;
    else                      r = ROLE_OFF;
    return r;
  endfunction

endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_chan_cap.sv
module tmr_chan_cap
  import tmr_chan_pkg::*;
#(
  parameter int PRE_A = 4,
  parameter int PRE_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       active,
  input  logic [3:0] mode,
  input  logic       alt_sel,
  input  logic       pin_s,
  input  logic       alt_evt,
  output logic       fire
);
  localparam int PMAX = (PRE_A > PRE_B) ? PRE_A : PRE_B;
  localparam int CW   = (PMAX > 2) ? $clog2(PMAX) : 1;

  logic          pin_d_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, fall, evt;
  logic [CW-1:0] limit;

  assign rise = pin_s & ~pin_d_q;
  assign fall = ~pin_s & pin_d_q;

  always_comb begin
    if (alt_sel)             evt = alt_evt;
    else if (mode == M_FALL) evt = fall;
    else                     evt = rise;
  end

  always_comb begin
    case (mode)
      M_PRE_A: limit = CW'(PRE_A - 1);
      M_PRE_B: limit = CW'(PRE_B - 1);
      default: limit = '0;
    endcase
  end

  assign fire = active & evt & (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (active && evt)   cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pin_d_q <= pin_s;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/tmr_chan_cmp.sv
module tmr_chan_cmp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr,
  input  logic [TW-1:0] ref_val,
  output logic          hit
);
  logic match, match_q;

  assign match = (tmr == ref_val);
  assign hit   = match & ~match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end
endmodule

// File: rtl/tmr_chan_pwm.sv
module tmr_chan_pwm #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic          roll,
  input  logic [DW-1:0] duty_in,
  output logic          pin
);
  localparam logic [DW-1:0] CMAX = '1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] duty_q, duty_d;
  logic          pin_q, pin_d;

  always_comb begin
    cnt_d  = cnt_q;
    duty_d = duty_q;
    pin_d  = pin_q;
    if (clr || !active) begin
      cnt_d  = '0;
      duty_d = '0;
      pin_d  = 1'b0;
    end else if (roll) begin
      duty_d = duty_in;
      cnt_d  = {{(DW-1){1'b0}}, 1'b1};
      pin_d  = (duty_in != '0);
    end else begin
      if (cnt_q == duty_q) pin_d = 1'b0;
      if (cnt_q != CMAX)   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      duty_q <= duty_d;
      pin_q  <= pin_d;
    end
  end

  assign pin = pin_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DW     = 10,
  parameter int SYNC_N = 2,
  parameter int PRE_A  = 4,
  parameter int PRE_B  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic          alt_evt,
  input  logic [TW-1:0] tmr_val,
  input  logic          pwm_roll,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  output logic          pin_out,
  output logic          irq_flag,
  output logic          spec_evt,
  output logic [TW-1:0] cap_val
);
  localparam int DHI = DW - 2;

  logic [3:0]    mode_q, mode_d;
  logic [1:0]    dlo_q, dlo_d;
  logic          alt_q, alt_d;
  logic [TW-1:0] val_q, val_d;
  logic          pin_q, pin_d;
  logic          flag_q, flag_d;
  logic          spec_q, spec_d;

  logic  ctrl_wr, vlo_wr, vhi_wr, flag_clr_w;
  logic  mode_chg, unit_clr;
  role_e role;
  logic  pin_s, cap_fire, cmp_hit, cmp_evt, pwm_pin;

  assign ctrl_wr    = wr_en && (wr_addr == ADR_CTRL);
  assign vlo_wr     = wr_en && (wr_addr == ADR_VLO);
  assign vhi_wr     = wr_en && (wr_addr == ADR_VHI);
  assign flag_clr_w = wr_en && (wr_addr == ADR_FCLR) && wr_data[0];
  assign mode_chg   = ctrl_wr && (wr_data[3:0] != mode_q);
  assign role       = role_of(mode_q);
  assign unit_clr   = mode_chg || (role == ROLE_OFF);

  tmr_chan_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  tmr_chan_cap #(.PRE_A(PRE_A), .PRE_B(PRE_B)) cap_i (
    .clk(clk), .rst_n(rst_n), .clr(unit_clr), .active(role == ROLE_CAP),
    .mode(mode_q), .alt_sel(alt_q), .pin_s(pin_s), .alt_evt(alt_evt),
    .fire(cap_fire)
  );

  tmr_chan_cmp #(.TW(TW)) cmp_i (
    .clk(clk), .rst_n(rst_n), .tmr(tmr_val), .ref_val(val_q), .hit(cmp_hit)
  );

  tmr_chan_pwm #(.DW(DW)) pwm_i (
    .clk(clk), .rst_n(rst_n), .clr(unit_clr), .active(role == ROLE_PWM),
    .roll(pwm_roll), .duty_in({val_q[DHI-1:0], dlo_q}), .pin(pwm_pin)
  );

  assign cmp_evt = cmp_hit && (role == ROLE_CMP);

  // control register
  always_comb begin
    mode_d = mode_q;
    dlo_d  = dlo_q;
    alt_d  = alt_q;
    if (ctrl_wr) begin
      mode_d = wr_data[3:0];
      dlo_d  = wr_data[5:4];
      alt_d  = wr_data[7];
    end
  end

  // value register: capture has priority over a software write
  always_comb begin
    val_d = val_q;
    if (vlo_wr) val_d[7:0]    = wr_data;
    if (vhi_wr) val_d[TW-1:8] = wr_data[TW-9:0];
    if (cap_fire) val_d = tmr_val;
  end

  // pin, flag and special-event pulse
  always_comb begin
    pin_d = pin_q;
    if (mode_chg) begin
      case (wr_data[3:0])
        M_SET_LO:                  pin_d = 1'b1;
        M_TOGGLE, M_IRQ, M_SPECIAL: pin_d = pin_q;
        default:                   pin_d = 1'b0;
      endcase
    end else if (cmp_evt) begin
      case (mode_q)
        M_TOGGLE: pin_d = ~pin_q;
        M_SET_HI: pin_d = 1'b1;
        M_SET_LO: pin_d = 1'b0;
        default:  pin_d = pin_q;
      endcase
    end

    spec_d = cmp_evt && (mode_q == M_SPECIAL);

    flag_d = flag_q;
    if (role == ROLE_OFF)         flag_d = 1'b0;
    else if (cap_fire || cmp_evt) flag_d = 1'b1;
    else if (flag_clr_w)          flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dlo_q  <= '0;
      alt_q  <= 1'b0;
      val_q  <= '0;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      spec_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dlo_q  <= dlo_d;
      alt_q  <= alt_d;
      val_q  <= val_d;
      pin_q  <= pin_d;
      flag_q <= flag_d;
      spec_q <= spec_d;
    end
  end

  assign pin_out  = (role == ROLE_PWM) ? pwm_pin : pin_q;
  assign irq_flag = flag_q;
  assign spec_evt = spec_q;
  assign cap_val  = val_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_q,
  input logic       pin_out,
  input logic       irq_flag,
  input logic       spec_evt,
  input logic       pwm_roll,
  input logic       flag_clr
);
  // R3: a channel that stays disabled keeps flag, pin and pulse low
  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (role_of(mode_q) == ROLE_OFF && role_of($past(mode_q)) == ROLE_OFF)
      |-> (!irq_flag && !pin_out && !spec_evt));

  // R7: the flag is sticky without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flag) && !$past(flag_clr) && role_of($past(mode_q)) != ROLE_OFF)
      |-> irq_flag);

  // R10: interrupt-only compare never moves the pin
  assert_irq_pin_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_IRQ && $past(mode_q) == M_IRQ) |-> $stable(pin_out));

  // R11: the special pulse is one cycle long
  assert_spec_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spec_evt |=> !spec_evt);

  // R11: the special pulse only follows the timer-reset mode
  assert_spec_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spec_evt |-> ($past(mode_q) == M_SPECIAL));

  // R12: in steady PWM the pin rises only at a rollover
  assert_pwm_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pin_out) && role_of(mode_q) == ROLE_PWM && role_of($past(mode_q)) == ROLE_PWM)
      |-> $past(pwm_roll));
endmodule

bind tmr_chan tmr_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .pin_out(pin_out),
  .irq_flag(irq_flag), .spec_evt(spec_evt), .pwm_roll(pwm_roll),
  .flag_clr(flag_clr_w)
);

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        alt_evt = 1'b0;
  logic [15:0] tmr_val = 16'h0;
  logic        pwm_roll = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'h0;
  logic        pin_out, irq_flag, spec_evt;
  logic [15:0] cap_val;

  int n_chk = 0;
  int n_bad = 0;
  int hi_total = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_chan dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .alt_evt(alt_evt),
    .tmr_val(tmr_val), .pwm_roll(pwm_roll), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_out(pin_out), .irq_flag(irq_flag),
    .spec_evt(spec_evt), .cap_val(cap_val)
  );

  always @(posedge clk) if (pin_out) hi_total <= hi_total + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_val(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic pin_pulse(input logic [15:0] t);
    tmr_val = t;
    pin_in = 1'b1; tick(4);
    pin_in = 1'b0; tick(4);
  endtask

  task automatic t_reset;
    chk("R1 pin", pin_out, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 spec", spec_evt, 0);
    chk("R1 value", cap_val, 16'h0);
  endtask

  task automatic t_write_disabled;
    set_val(16'hBEEF);
    chk("R2 value write", cap_val, 16'hBEEF);
    wr(2'd0, 8'h00);
    pin_pulse(16'h4321);
    chk("R3 no capture when off", cap_val, 16'hBEEF);
    wr(2'd0, 8'h01);
    pin_pulse(16'h4322);
    chk("R3 reserved 0001 no capture", cap_val, 16'hBEEF);
    chk("R3 reserved flag", irq_flag, 0);
  endtask

  task automatic t_edges;
    wr(2'd0, 8'h05);
    pin_pulse(16'h1234);
    chk("R4 rising capture", cap_val, 16'h1234);
    chk("R7 flag on capture", irq_flag, 1);
    wr(2'd3, 8'h01);
    chk("R7 flag clear", irq_flag, 0);
    wr(2'd0, 8'h04);
    tmr_val = 16'h7777; pin_in = 1'b1; tick(4);
    chk("R4 falling mode ignores rise", cap_val, 16'h1234);
    tmr_val = 16'h2222; pin_in = 1'b0; tick(4);
    chk("R4 falling capture", cap_val, 16'h2222);
  endtask

  task automatic t_prescale;
    wr(2'd0, 8'h06);
    wr(2'd3, 8'h01);
    for (int i = 0; i < 3; i++) pin_pulse(16'h0100 + 16'(i));
    chk("R5 no capture before 4th", cap_val, 16'h2222);
    pin_pulse(16'hAAAA);
    chk("R5 capture on 4th", cap_val, 16'hAAAA);
    wr(2'd0, 8'h07);
    for (int i = 0; i < 15; i++) pin_pulse(16'h0200 + 16'(i));
    chk("R5 no capture before 16th", cap_val, 16'hAAAA);
    pin_pulse(16'hBBBB);
    chk("R5 capture on 16th", cap_val, 16'hBBBB);
    wr(2'd0, 8'h06);
    pin_pulse(16'h0301);
    pin_pulse(16'h0302);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h06);
    for (int i = 0; i < 3; i++) pin_pulse(16'h0400 + 16'(i));
    chk("R3 prescaler restarted by disable", cap_val, 16'hBBBB);
    pin_pulse(16'hCCCC);
    chk("R5 capture after restart", cap_val, 16'hCCCC);
  endtask

  task automatic t_alt;
    wr(2'd0, 8'h85);
    wr(2'd3, 8'h01);
    pin_pulse(16'h5151);
    chk("R6 pin ignored with alternate source", cap_val, 16'hCCCC);
    tmr_val = 16'h0BEE;
    @(negedge clk); alt_evt = 1'b1;
    @(negedge clk); alt_evt = 1'b0;
    chk("R6 alternate capture", cap_val, 16'h0BEE);
    chk("R7 flag from alternate", irq_flag, 1);
    wr(2'd3, 8'h01);
    tmr_val = 16'h0C0C;
    @(negedge clk);
    alt_evt = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    @(negedge clk);
    alt_evt = 1'b0; wr_en = 1'b0;
    chk("R7 event beats clear", irq_flag, 1);
    chk("R6 capture in collision", cap_val, 16'h0C0C);
  endtask

  task automatic t_compare;
    tmr_val = 16'h00F0;
    wr(2'd0, 8'h00);
    set_val(16'h0100);
    wr(2'd0, 8'h02);
    chk("R8 toggle entry low", pin_out, 0);
    tmr_val = 16'h0100; tick(1);
    chk("R8 toggle to high", pin_out, 1);
    chk("R7 flag on match", irq_flag, 1);
    tick(3);
    chk("R8 held match single toggle", pin_out, 1);
    tmr_val = 16'h0101; tick(1);
    tmr_val = 16'h0100; tick(1);
    chk("R8 toggle to low", pin_out, 0);
    tmr_val = 16'h0101; tick(1);
    tmr_val = 16'h0100; tick(1);
    chk("R8 toggle high again", pin_out, 1);
    tmr_val = 16'h0103;
    wr(2'd0, 8'h08);
    chk("R9 set-high mode enters low", pin_out, 0);
    tmr_val = 16'h0100; tick(1);
    chk("R9 match forces high", pin_out, 1);
    tmr_val = 16'h0104;
    wr(2'd0, 8'h09);
    wr(2'd0, 8'h08);
    chk("R9 re-entry low", pin_out, 0);
    wr(2'd0, 8'h09);
    chk("R9 set-low mode enters high", pin_out, 1);
    tmr_val = 16'h0100; tick(1);
    chk("R9 match forces low", pin_out, 0);
    tmr_val = 16'h0105;
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h09);
    wr(2'd0, 8'h0A);
    wr(2'd3, 8'h01);
    chk("R10 entry keeps pin", pin_out, 1);
    tmr_val = 16'h0100; tick(1);
    chk("R10 flag set", irq_flag, 1);
    chk("R10 pin untouched", pin_out, 1);
    tmr_val = 16'h0106;
    wr(2'd0, 8'h0B);
    wr(2'd3, 8'h01);
    tmr_val = 16'h0100; tick(1);
    chk("R11 pulse", spec_evt, 1);
    chk("R11 flag", irq_flag, 1);
    tick(1);
    chk("R11 pulse ends", spec_evt, 0);
    tmr_val = 16'h0107;
    wr(2'd0, 8'h03);
    tmr_val = 16'h0100; tick(2);
    chk("R3 reserved 0011 flag", irq_flag, 0);
    chk("R3 reserved 0011 pulse", spec_evt, 0);
    chk("R3 reserved 0011 pin", pin_out, 0);
  endtask

  task automatic roll;
    @(negedge clk); pwm_roll = 1'b1;
    @(negedge clk); pwm_roll = 1'b0;
  endtask

  task automatic t_pwm;
    int start;
    tmr_val = 16'h0000;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h1C);
    chk("R12 pwm entry low", pin_out, 0);
    roll; start = hi_total;
    chk("R12 high at roll", pin_out, 1);
    wr(2'd1, 8'd1);
    wr(2'd0, 8'h2C);
    tick(30);
    chk("R12 duty 13 high cycles", hi_total - start, 13);
    chk("R12 low after duty", pin_out, 0);
    roll; start = hi_total;
    tick(30);
    chk("R12 new duty 6 from next roll", hi_total - start, 6);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h0C);
    roll; start = hi_total;
    chk("R13 zero duty low at roll", pin_out, 0);
    tick(30);
    chk("R13 zero duty no high cycles", hi_total - start, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset;
    t_write_disabled;
    t_edges;
    t_prescale;
    t_alt;
    t_compare;
    t_pwm;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule